// File: doc/BRIEF.md
# Modem Host Register Interface

This block links an 8-bit microcontroller bus to a modem core. Each host access is a one-cycle strobe that carries a direction and a 2-bit address. A write reaches one of four registers: the buffer port, the command register, the control register or the mode register. A read reaches one of three sources: the buffer port, the status word or the data-quality byte. The fourth read address returns a fixed byte. The 12-byte transfer buffer sits behind a single address. An internal pointer advances on every accepted buffer access, so the host streams bytes one after another without addressing each one.

The modem side is modelled as a plain producer and consumer. In receive mode the modem writes bytes into the buffer by index, and it may do so at any time. It then pulses a done strobe to hand the buffer to the host. In transmit mode the modem reads the bytes by index once the host has filled the buffer, and pulses done to give the buffer back. A buffer-free flag in the status word tells the host when the buffer is its to use. A programmable minimum spacing between host accesses is enforced. An access that comes too early is dropped and recorded in a sticky error bit.

Top module: `modem_host_if`

## Requirements
- R1: Accepted writes with address 2'b01 load `cmd_o` and raise `cmd_stb_o` for exactly the following cycle. Address 2'b10 loads `ctrl_o` and address 2'b11 loads `mode_o`. Bit 0 of `mode_o` selects transmit (1) or receive (0).
- R2: An accepted read updates `host_rdata_o` one cycle after the strobe. Address 2'b01 returns the status byte {buffer-free, access-error, `mdm_stat_i[5:0]`}, with buffer-free in bit 7 and access-error in bit 6. Address 2'b10 returns `mdm_quality_i`. Address 2'b11 returns 8'h00.
- R3: In transmit mode with buffer-free set, successive host writes to address 2'b00 fill buffer locations 0, 1, 2 and so on in order. The modem sees them on `mdm_rd_data_o` at the matching `mdm_rd_idx_i`.
- R4: In receive mode with buffer-free set, successive host reads of address 2'b00 return buffer locations in ascending order.
- R5: Buffer-free clears when the twelfth buffer byte since the last pointer reset is accepted.
- R6: A `mdm_done_i` pulse while buffer-free is clear sets buffer-free, and the next buffer access uses location 0.
- R7: An accepted command write returns the buffer pointer to location 0.
- R8: The following are ignored: a buffer write in receive mode, a buffer read in transmit mode, and any buffer access while buffer-free is clear. The buffer contents and the pointer stay as they were, and an ignored read returns 8'h00.
- R9: An access that arrives fewer than `MIN_GAP` cycles after the previous accepted access is dropped, and the access-error bit is set.
- R10: The access-error bit stays set until an accepted status read. That read returns the bit as set and then clears it.
- R11: In receive mode, modem writes land in the buffer whether or not the host has read the earlier contents. New data overwrites old data.
- R12: After reset, `cmd_o`, `ctrl_o`, `mode_o`, `host_rdata_o` and `cmd_stb_o` are zero, buffer-free is set and the access-error bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_cs_i | input | 1 | One-cycle host access strobe |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_addr_i | input | 2 | Register select |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Registered host read data |
| mdm_stat_i | input | 6 | Modem status bits shown in status[5:0] |
| mdm_quality_i | input | 8 | Modem data-quality byte |
| mdm_done_i | input | 1 | Modem has filled (Rx) or taken (Tx) the buffer |
| mdm_wr_en_i | input | 1 | Modem buffer write enable (receive mode) |
| mdm_wr_idx_i | input | 4 | Modem write location |
| mdm_wr_data_i | input | 8 | Modem write byte |
| mdm_rd_idx_i | input | 4 | Modem read location |
| mdm_rd_data_o | output | 8 | Buffer byte at `mdm_rd_idx_i` |
| buf_free_o | output | 1 | Buffer-free flag |
| cmd_o | output | 8 | Command register |
| cmd_stb_o | output | 1 | Pulse after a command write |
| ctrl_o | output | 8 | Control register |
| mode_o | output | 8 | Mode register |

## Verification
A table walks writes and reads across all four addresses in both directions. Because the read and write maps differ, this shows whether a read is decoded through the write map or the reverse. A receive sequence reads part of the buffer, resets the pointer with a command write, and then reads through to the twelfth byte. The byte values show whether the pointer restarts and where buffer-free drops. Wrong-direction accesses and accesses while the buffer is not free are each followed by an access that exposes the pointer and the contents. A pair of accesses one cycle apart, followed by two status reads, separates dropping an early access from accepting it, and a sticky error from one that clears.

// File: rtl/modem_hif_pkg.sv
// Package: shared address encoding and constants for the modem host interface.
// Assumes an 8-bit host data bus.
package modem_hif_pkg;

    localparam int HIF_DW = 8;

    typedef enum logic [1:0] {
        A_BUF      = 2'b00,   // buffer port (read and write)
        A_CMD_STAT = 2'b01,   // write: command, read: status
        A_CTRL_DQ  = 2'b10,   // write: control, read: data quality
        A_MODE_NA  = 2'b11    // write: mode, read: fixed value
    } hif_addr_e;

    localparam logic [HIF_DW-1:0] UNUSED_RD = '0;

endpackage

// File: rtl/hif_gap_timer.sv
// Module: enforces a minimum spacing between accepted host accesses.
// An access is accepted only when MIN_GAP cycles have passed since the last
// accepted one. Rejected accesses do not restart the window.
// Assumes MIN_GAP >= 1.
module hif_gap_timer #(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    output logic accept_o,
    output logic early_o
);
    localparam int CNT_W = (MIN_GAP > 1) ? $clog2(MIN_GAP) : 1;

    logic [CNT_W-1:0] wait_q;

    assign accept_o = req_i && (wait_q == '0);
    assign early_o  = req_i && (wait_q != '0);

    // Load the hold-off window on acceptance, then count it down.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wait_q <= '0;
        else if (accept_o)
            wait_q <= CNT_W'(MIN_GAP - 1);
        else if (wait_q != '0)
            wait_q <= wait_q - 1'b1;
    end

    generate
        if (MIN_GAP > 1) begin : g_spacing_chk
            assert_gap_spacing_R9: assert property (@(posedge clk) disable iff (!rst_n)
                accept_o |=> !accept_o)
                else $error("accesses accepted on back-to-back cycles");
        end
    endgenerate

endmodule

// File: rtl/hif_buffer.sv
// Module: the transfer buffer, its auto-stepping host pointer and the
// buffer-free flag. The host side steps through the locations in order.
// The modem side addresses them directly.
// Assumes host_wr_i/host_rd_i are already spacing-qualified and address-decoded.
module hif_buffer #(
    parameter int DEPTH = 12,
    parameter int DW    = 8,
    parameter int IDX_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_mode_i,
    input  logic             host_wr_i,
    input  logic             host_rd_i,
    input  logic [DW-1:0]    host_wdata_i,
    input  logic             ptr_clr_i,
    input  logic             mdm_done_i,
    input  logic             mdm_wr_en_i,
    input  logic [IDX_W-1:0] mdm_wr_idx_i,
    input  logic [DW-1:0]    mdm_wr_data_i,
    input  logic [IDX_W-1:0] mdm_rd_idx_i,
    output logic [DW-1:0]    mdm_rd_data_o,
    output logic [DW-1:0]    host_rd_byte_o,
    output logic             bfree_o
);
    logic [DW-1:0]    mem_q [DEPTH];
    logic [IDX_W-1:0] ptr_q;
    logic             bfree_q;
    logic             wr_ok, rd_ok, step, at_last, refill;
    logic [DW-1:0]    ptr_byte;

    assign wr_ok   = host_wr_i &&  tx_mode_i && bfree_q;
    assign rd_ok   = host_rd_i && !tx_mode_i && bfree_q;
    assign step    = wr_ok || rd_ok;
    assign at_last = (ptr_q == IDX_W'(DEPTH - 1));
    assign refill  = mdm_done_i && !bfree_q;
    assign bfree_o = bfree_q;

    // Buffer-free flag: drops on the final byte, returns on the modem hand-back.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bfree_q <= 1'b1;
        else if (step && at_last)
            bfree_q <= 1'b0;
        else if (refill)
            bfree_q <= 1'b1;
    end

    // Host pointer: home on hand-back or command, advance on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (refill || ptr_clr_i)
            ptr_q <= '0;
        else if (step)
            ptr_q <= ptr_q + 1'b1;
    end

    // One storage byte per location; host writes in Tx, modem writes in Rx.
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_byte
            always_ff @(posedge clk) begin
                if (wr_ok && ptr_q == IDX_W'(g))
                    mem_q[g] <= host_wdata_i;
                else if (mdm_wr_en_i && !tx_mode_i && mdm_wr_idx_i == IDX_W'(g))
                    mem_q[g] <= mdm_wr_data_i;
            end
        end
    endgenerate

    // Read muxes for the modem port and the host pointer location.
    always_comb begin
        mdm_rd_data_o = '0;
        ptr_byte      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (mdm_rd_idx_i == IDX_W'(i)) mdm_rd_data_o = mem_q[i];
            if (ptr_q == IDX_W'(i))        ptr_byte      = mem_q[i];
        end
    end

    // Host read byte: the pointed location, or zero for a gated read.
    assign host_rd_byte_o = rd_ok ? ptr_byte : '0;

    assert_bfree_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && at_last) |=> !bfree_q)
        else $error("buffer-free still set after final byte");

    assert_ptr_home_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bfree_q) |-> (ptr_q == '0))
        else $error("pointer not at zero when buffer-free returns");

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !ptr_clr_i && !refill) |=> $stable(ptr_q))
        else $error("pointer moved without an accepted access");

    assert_ptr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= IDX_W'(DEPTH))
        else $error("pointer beyond buffer end");

endmodule

// File: rtl/hif_regs.sv
// Module: command, control and mode registers plus the sticky access-error bit.
// Assumes the write strobes are decoded and spacing-qualified by the caller.
module hif_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_cmd_i,
    input  logic          wr_ctrl_i,
    input  logic          wr_mode_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          early_i,
    input  logic          stat_rd_i,
    output logic [DW-1:0] cmd_o,
    output logic          cmd_stb_o,
    output logic [DW-1:0] ctrl_o,
    output logic [DW-1:0] mode_o,
    output logic          acc_err_o
);
    // Register loads and the one-cycle command pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_o     <= '0;
            ctrl_o    <= '0;
            mode_o    <= '0;
            cmd_stb_o <= 1'b0;
        end else begin
            cmd_stb_o <= wr_cmd_i;
            if (wr_cmd_i)  cmd_o  <= wdata_i;
            if (wr_ctrl_i) ctrl_o <= wdata_i;
            if (wr_mode_i) mode_o <= wdata_i;
        end
    end

    // Sticky error: set by an early access, cleared by an accepted status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_err_o <= 1'b0;
        else if (early_i)
            acc_err_o <= 1'b1;
        else if (stat_rd_i)
            acc_err_o <= 1'b0;
    end

    assert_cmd_stb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd_i |=> cmd_stb_o)
        else $error("command strobe missing");

    assert_err_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        early_i |=> acc_err_o)
        else $error("early access not recorded");

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_err_o && !stat_rd_i) |=> acc_err_o)
        else $error("error bit cleared without status read");

endmodule

// File: rtl/modem_host_if.sv
// Module: top of the modem host register interface. Decodes host accesses
// through the spacing timer, routes them to the buffer and register bank,
// and registers the read data.
// Assumes host strobes are synchronous to clk and one cycle long.
module modem_host_if
    import modem_hif_pkg::*;
#(
    parameter int BUF_DEPTH = 12,
    parameter int MIN_GAP   = 4,
    parameter int IDX_W     = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cs_i,
    input  logic              host_we_i,
    input  logic [1:0]        host_addr_i,
    input  logic [HIF_DW-1:0] host_wdata_i,
    output logic [HIF_DW-1:0] host_rdata_o,
    input  logic [HIF_DW-3:0] mdm_stat_i,
    input  logic [HIF_DW-1:0] mdm_quality_i,
    input  logic              mdm_done_i,
    input  logic              mdm_wr_en_i,
    input  logic [IDX_W-1:0]  mdm_wr_idx_i,
    input  logic [HIF_DW-1:0] mdm_wr_data_i,
    input  logic [IDX_W-1:0]  mdm_rd_idx_i,
    output logic [HIF_DW-1:0] mdm_rd_data_o,
    output logic              buf_free_o,
    output logic [HIF_DW-1:0] cmd_o,
    output logic              cmd_stb_o,
    output logic [HIF_DW-1:0] ctrl_o,
    output logic [HIF_DW-1:0] mode_o
);
    logic              acc, early, acc_wr, acc_rd, acc_err;
    logic [HIF_DW-1:0] buf_byte;
    hif_addr_e         addr;

    assign addr   = hif_addr_e'(host_addr_i);
    assign acc_wr = acc &&  host_we_i;
    assign acc_rd = acc && !host_we_i;

    hif_gap_timer #(.MIN_GAP(MIN_GAP)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (host_cs_i),
        .accept_o (acc),
        .early_o  (early)
    );

    hif_buffer #(.DEPTH(BUF_DEPTH), .DW(HIF_DW), .IDX_W(IDX_W)) u_buf (
        .clk            (clk),
        .rst_n          (rst_n),
        .tx_mode_i      (mode_o[0]),
        .host_wr_i      (acc_wr && addr == A_BUF),
        .host_rd_i      (acc_rd && addr == A_BUF),
        .host_wdata_i   (host_wdata_i),
        .ptr_clr_i      (acc_wr && addr == A_CMD_STAT),
        .mdm_done_i     (mdm_done_i),
        .mdm_wr_en_i    (mdm_wr_en_i),
        .mdm_wr_idx_i   (mdm_wr_idx_i),
        .mdm_wr_data_i  (mdm_wr_data_i),
        .mdm_rd_idx_i   (mdm_rd_idx_i),
        .mdm_rd_data_o  (mdm_rd_data_o),
        .host_rd_byte_o (buf_byte),
        .bfree_o        (buf_free_o)
    );

    hif_regs #(.DW(HIF_DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_cmd_i  (acc_wr && addr == A_CMD_STAT),
        .wr_ctrl_i (acc_wr && addr == A_CTRL_DQ),
        .wr_mode_i (acc_wr && addr == A_MODE_NA),
        .wdata_i   (host_wdata_i),
        .early_i   (early),
        .stat_rd_i (acc_rd && addr == A_CMD_STAT),
        .cmd_o     (cmd_o),
        .cmd_stb_o (cmd_stb_o),
        .ctrl_o    (ctrl_o),
        .mode_o    (mode_o),
        .acc_err_o (acc_err)
    );

    // Read data register: selected source latched on each accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata_o <= '0;
        else if (acc_rd) begin
            unique case (addr)
                A_BUF:      host_rdata_o <= buf_byte;
                A_CMD_STAT: host_rdata_o <= {buf_free_o, acc_err, mdm_stat_i};
                A_CTRL_DQ:  host_rdata_o <= mdm_quality_i;
                A_MODE_NA:  host_rdata_o <= UNUSED_RD;
            endcase
        end
    end

    assert_unused_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && host_addr_i == 2'b11) |=> (host_rdata_o == UNUSED_RD))
        else $error("unused address returned non-fixed data");

    assert_early_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cs_i && host_we_i && host_addr_i == 2'b10 && !acc) |=> $stable(ctrl_o))
        else $error("early control write took effect");

endmodule

// File: tb/modem_host_if_tb_top.sv
`timescale 1ns/1ps
module modem_host_if_tb_top;

    localparam int GAP   = 4;
    localparam int DEPTH = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, we = 1'b0;
    logic [1:0] addr = 2'b00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [5:0] stat = 6'h15;
    logic [7:0] dq = 8'hA7;
    logic       done = 1'b0, mwe = 1'b0;
    logic [3:0] mwidx = 4'd0, mridx = 4'd0;
    logic [7:0] mwdata = 8'h00, mrdata;
    logic       bfree, cmd_stb;
    logic [7:0] cmd, ctrl, mode;

    int  nvec = 0, nfail = 0;
    bit  finished = 1'b0;
    logic [7:0] last_rd;

    always #2.5 clk = ~clk;

    modem_host_if #(.BUF_DEPTH(DEPTH), .MIN_GAP(GAP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_cs_i(cs), .host_we_i(we), .host_addr_i(addr),
        .host_wdata_i(wdata), .host_rdata_o(rdata),
        .mdm_stat_i(stat), .mdm_quality_i(dq), .mdm_done_i(done),
        .mdm_wr_en_i(mwe), .mdm_wr_idx_i(mwidx), .mdm_wr_data_i(mwdata),
        .mdm_rd_idx_i(mridx), .mdm_rd_data_o(mrdata),
        .buf_free_o(bfree), .cmd_o(cmd), .cmd_stb_o(cmd_stb),
        .ctrl_o(ctrl), .mode_o(mode)
    );

    typedef enum logic [1:0] {S_RD, S_CTRL, S_MODE, S_CMD} sel_e;
    typedef struct packed {
        logic       we;
        logic [1:0] addr;
        logic [7:0] data;
        sel_e       sel;
        logic [7:0] exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'b10, 8'h3C, S_CTRL, 8'h3C},
        '{1'b0, 2'b10, 8'h00, S_RD,   8'hA7},
        '{1'b0, 2'b11, 8'h00, S_RD,   8'h00},
        '{1'b1, 2'b01, 8'h5A, S_CMD,  8'h5A},
        '{1'b0, 2'b01, 8'h00, S_RD,   8'h95},
        '{1'b1, 2'b11, 8'h80, S_MODE, 8'h80},
        '{1'b1, 2'b10, 8'hC3, S_CTRL, 8'hC3},
        '{1'b0, 2'b11, 8'h00, S_RD,   8'h00}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a negedge; one accepted access, then idle to respect spacing.
    task automatic acc(input logic w, input logic [1:0] a, input logic [7:0] d);
        cs = 1'b1; we = w; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0;
        last_rd = rdata;
        repeat (GAP - 1) @(negedge clk);
    endtask

    task automatic mfill(input logic [3:0] i, input logic [7:0] d);
        mwe = 1'b1; mwidx = i; mwdata = d;
        @(negedge clk);
        mwe = 1'b0;
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset state
        chk("R12 cmd", cmd, 8'h00);
        chk("R12 ctrl", ctrl, 8'h00);
        chk("R12 mode", mode, 8'h00);
        chk("R12 rdata", rdata, 8'h00);
        chk("R12 stb", {7'd0, cmd_stb}, 8'h00);
        acc(1'b0, 2'b01, 8'h00);
        chk("R12 status", last_rd, 8'h95);

        // R1 / R2: register map table
        for (int v = 0; v < NV; v++) begin
            acc(VECS[v].we, VECS[v].addr, VECS[v].data);
            case (VECS[v].sel)
                S_RD:    chk("R2 read map", last_rd, VECS[v].exp);
                S_CTRL:  chk("R1 ctrl", ctrl, VECS[v].exp);
                S_MODE:  chk("R1 mode", mode, VECS[v].exp);
                default: chk("R1 cmd", cmd, VECS[v].exp);
            endcase
        end

        // R1: command strobe lasts one cycle
        cs = 1'b1; we = 1'b1; addr = 2'b01; wdata = 8'h11;
        @(negedge clk);
        cs = 1'b0;
        chk("R1 stb high", {7'd0, cmd_stb}, 8'h01);
        @(negedge clk);
        chk("R1 stb low", {7'd0, cmd_stb}, 8'h00);
        repeat (GAP - 2) @(negedge clk);

        // R4 / R7 / R5: receive reads, pointer reset by command
        for (int i = 0; i < DEPTH; i++) mfill(4'(i), 8'h40 + 8'(i));
        for (int i = 0; i < 5; i++) begin
            acc(1'b0, 2'b00, 8'h00);
            chk("R4 rx read", last_rd, 8'h40 + 8'(i));
        end
        acc(1'b1, 2'b01, 8'h01);
        acc(1'b0, 2'b00, 8'h00);
        chk("R7 ptr reset", last_rd, 8'h40);
        for (int i = 1; i < DEPTH; i++) begin
            acc(1'b0, 2'b00, 8'h00);
            chk("R4 rx read", last_rd, 8'h40 + 8'(i));
        end
        acc(1'b0, 2'b01, 8'h00);
        chk("R5 bfree clear rx", last_rd, 8'h15);
        acc(1'b0, 2'b00, 8'h00);
        chk("R8 read not free", last_rd, 8'h00);

        // R11 / R6: modem overwrites unread data, done restores buffer-free
        mfill(4'd0, 8'h99);
        pulse_done();
        acc(1'b0, 2'b01, 8'h00);
        chk("R6 bfree set", last_rd, 8'h95);
        acc(1'b0, 2'b00, 8'h00);
        chk("R11 overwrite", last_rd, 8'h99);

        // R8: host write in receive mode ignored
        acc(1'b1, 2'b00, 8'h77);
        acc(1'b0, 2'b00, 8'h00);
        chk("R8 rx write ignored", last_rd, 8'h41);
        mridx = 4'd1;
        #1 chk("R8 rx contents", mrdata, 8'h41);

        // R3: transmit fill; read in Tx ignored
        acc(1'b1, 2'b11, 8'h01);
        acc(1'b1, 2'b01, 8'h02);
        acc(1'b0, 2'b00, 8'h00);
        chk("R8 tx read ignored", last_rd, 8'h00);
        for (int i = 0; i < DEPTH; i++) acc(1'b1, 2'b00, 8'hC0 + 8'(i));
        for (int i = 0; i < DEPTH; i++) begin
            mridx = 4'(i);
            #1 chk("R3 tx fill", mrdata, 8'hC0 + 8'(i));
        end
        acc(1'b0, 2'b01, 8'h00);
        chk("R5 bfree clear tx", last_rd, 8'h15);
        acc(1'b1, 2'b00, 8'hEE);
        mridx = 4'd0;
        #1 chk("R8 write not free", mrdata, 8'hC0);
        pulse_done();
        acc(1'b1, 2'b00, 8'hD0);
        #1 chk("R6 ptr home", mrdata, 8'hD0);

        // R9 / R10: early access dropped, sticky error cleared by status read
        cs = 1'b1; we = 1'b1; addr = 2'b10; wdata = 8'hAA;
        @(negedge clk);
        wdata = 8'h55;
        @(negedge clk);
        cs = 1'b0;
        repeat (GAP - 2) @(negedge clk);
        chk("R9 early dropped", ctrl, 8'hAA);
        acc(1'b0, 2'b01, 8'h00);
        chk("R9 error set", last_rd, 8'hD5);
        acc(1'b0, 2'b01, 8'h00);
        chk("R10 error cleared", last_rd, 8'h95);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule